// File: doc/BRIEF.md
# I2C Master Register Bank with FIFO Level Interrupts

This block is the software-visible side of an I2C master controller. A simple valid/write/address/data port gives access to a set of 32-bit registers. These include a control word, a target address, a transfer count, a high-speed configuration word, two clock divider words, a start-hold count, a read-only version word and a status word. Two byte-wide data ports sit in the same address space. A write to the transmit port queues a byte, and a read from the receive port takes the oldest received byte. A write-only flush location empties both queues at once.

Each direction has its own 16-entry byte FIFO. The I2C line engine is outside this block. It takes bytes from the transmit FIFO, pushes received bytes into the receive FIFO, and reports completion, missing acknowledge, busy and the sampled line levels through dedicated ports. Two programmable occupancy levels in the control word raise maskable requests. The receive side fires when it has collected enough bytes, and the transmit side fires when it is running low. These requests are merged with the sticky transfer-done flag into one interrupt line. Firmware clears the done and no-acknowledge flags by writing a zero to their bit positions.

Top module: `i2cm_regfile`

## Requirements
- R1: After reset, every writable register reads 0, both FIFOs are empty, and the interrupt line is low.
- R2: The word index is bus_addr[5:2]. Control (0), address (1), count (2), high-speed config (6), divider words (8, 9) and start-hold (10) store all 32 written bits and read them back. Index 7 reads the VERSION parameter. Unmapped indices, the transmit port (4) and the flush location (11) read 0. An access with bus_addr[1:0] not zero reads 0 and writes nothing.
- R3: A write to index 4 pushes bus_wdata[7:0] into the transmit FIFO, which the engine sees on eng_tx_data in arrival order and removes with eng_tx_pop. A push to a full (16-byte) FIFO is dropped.
- R4: A read of index 3 returns the oldest received byte in bits [7:0] and removes it. A read of the empty FIFO returns 0 and changes nothing. An engine push to a full receive FIFO is dropped.
- R5: A write to index 11 with bit 0 set empties both FIFOs in that cycle. With bit 0 clear, it has no effect.
- R6: The status word (index 5) carries the SDA level at bit 21, the SCL level at bit 20, transmit-FIFO-full at bit 4, receive-FIFO-empty at bit 3, done at bit 2, no-acknowledge at bit 1 and engine busy at bit 0. All other bits are 0.
- R7: The done and no-acknowledge flags are set by eng_done and eng_nack pulses. A status write clears a flag only where the written bit is 0. A set pulse in the same cycle wins over the clear.
- R8: The almost-full request is active while the receive occupancy is at or above control[19:16] and control bit 10 is set.
- R9: The almost-empty request is active while the transmit occupancy is at or below control[15:12] and control bit 9 is set.
- R10: irq is high exactly when control bit 1 is set and at least one of done, the almost-full request and the almost-empty request is active. It reflects the register state of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of a read access |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_data | output | BYTE_W | Head transmit byte, 0 when empty |
| eng_tx_avail | output | 1 | Transmit FIFO holds at least one byte |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | BYTE_W | Received byte |
| eng_done | input | 1 | Transfer-complete pulse |
| eng_nack | input | 1 | Missing-acknowledge pulse |
| eng_busy | input | 1 | Engine busy level |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| cfg_ctl | output | DATA_W | Control word to the engine |
| cfg_addr | output | DATA_W | Target address word |
| cfg_count | output | DATA_W | Transfer count word |
| cfg_hs | output | DATA_W | High-speed configuration word |
| cfg_div0 | output | DATA_W | First clock divider word |
| cfg_div1 | output | DATA_W | Second clock divider word |
| cfg_hold | output | DATA_W | Start-hold count |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong FIFO pointer or occupancy shows at the ports in the next cycle. It appears as a wrong byte on eng_tx_data or in a receive read, as a wrong full or empty status bit, or as a level interrupt that fires one byte early or late. The bench's reference model keeps the queues as plain lists and compares irq, the transmit head and bus_rdata every clock, so a divergence is reported in the cycle it first becomes visible. Lost or stuck done and no-acknowledge flags show on the next status read, and also on irq whenever the interrupt is enabled.

// File: rtl/i2cm_regfile_pkg.sv
package i2cm_regfile_pkg;
   // word index = byte address [5:2]
   typedef enum logic [3:0] {
      IDX_CTL   = 4'd0,
      IDX_ADDR  = 4'd1,
      IDX_COUNT = 4'd2,
      IDX_RXD   = 4'd3,
      IDX_TXD   = 4'd4,
      IDX_STAT  = 4'd5,
      IDX_HS    = 4'd6,
      IDX_VER   = 4'd7,
      IDX_DIV0  = 4'd8,
      IDX_DIV1  = 4'd9,
      IDX_HOLD  = 4'd10,
      IDX_FLUSH = 4'd11
   } reg_idx_e;

   localparam int LVL_W       = 4;
   localparam int CT_AF_LSB   = 16;
   localparam int CT_AE_LSB   = 12;
   localparam int CT_FULL_IE  = 10;
   localparam int CT_EMPTY_IE = 9;
   localparam int CT_IRQ_EN   = 1;

   localparam int ST_SDA     = 21;
   localparam int ST_SCL     = 20;
   localparam int ST_TXFULL  = 4;
   localparam int ST_RXEMPTY = 3;
   localparam int ST_DONE    = 2;
   localparam int ST_NACK    = 1;
   localparam int ST_BUSY    = 0;
endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/i2cm_irq_gen.sv
module i2cm_irq_gen #(
   parameter int CNT_W = 5,
   parameter int LVL_W = 4
) (
   input  logic [CNT_W-1:0] rx_cnt,
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic [LVL_W-1:0] af_lvl,
   input  logic [LVL_W-1:0] ae_lvl,
   input  logic             full_ie,
   input  logic             empty_ie,
   input  logic             irq_en,
   input  logic             done,
   output logic             irq_raw
);
   logic af_hit, ae_hit;

   assign af_hit  = full_ie  & (32'(rx_cnt) >= 32'(af_lvl));
   assign ae_hit  = empty_ie & (32'(tx_cnt) <= 32'(ae_lvl));
   assign irq_raw = irq_en & (done | af_hit | ae_hit);
endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
   import i2cm_regfile_pkg::*;
#(
   parameter int                DEPTH   = 16,
   parameter int                ADDR_W  = 6,
   parameter int                BYTE_W  = 8,
   parameter int                DATA_W  = 32,
   parameter logic [DATA_W-1:0] VERSION = 'h0101,
   parameter bit                IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              eng_tx_pop,
   output logic [BYTE_W-1:0] eng_tx_data,
   output logic              eng_tx_avail,
   input  logic              eng_rx_push,
   input  logic [BYTE_W-1:0] eng_rx_data,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic              eng_busy,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic [DATA_W-1:0] cfg_ctl,
   output logic [DATA_W-1:0] cfg_addr,
   output logic [DATA_W-1:0] cfg_count,
   output logic [DATA_W-1:0] cfg_hs,
   output logic [DATA_W-1:0] cfg_div0,
   output logic [DATA_W-1:0] cfg_div1,
   output logic [DATA_W-1:0] cfg_hold,
   output logic              irq
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < ST_SDA + 1) begin : g_bad_data
      $error("DATA_W too narrow for the status layout");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must cover twelve word locations");
   end
   if (BYTE_W > DATA_W) begin : g_bad_byte
      $error("BYTE_W must not exceed DATA_W");
   end

   logic              hit, wr_en, rd_en, upper_zero;
   logic [3:0]        idx;
   logic [DATA_W-1:0] ctl_q, addr_q, count_q, hs_q, div0_q, div1_q, hold_q;
   logic              done_q, nack_q;
   logic              flush_req, stat_clr_done, stat_clr_nack;
   logic              tx_push, rx_pop;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [BYTE_W-1:0] rx_head;
   logic [DATA_W-1:0] stat_w;
   logic              irq_en, irq_raw;

   // address decode: upper bits must be zero when the bus is wider
   if (ADDR_W > 6) begin : g_wide_addr
      assign upper_zero = ~|bus_addr[ADDR_W-1:6];
   end else begin : g_narrow_addr
      assign upper_zero = 1'b1;
   end

   assign idx   = bus_addr[5:2];
   assign hit   = bus_valid & upper_zero & (bus_addr[1:0] == 2'b00);
   assign wr_en = hit & bus_write;
   assign rd_en = hit & ~bus_write;

   assign tx_push       = wr_en & (idx == IDX_TXD);
   assign rx_pop        = rd_en & (idx == IDX_RXD);
   assign flush_req     = wr_en & (idx == IDX_FLUSH) & bus_wdata[0];
   assign stat_clr_done = wr_en & (idx == IDX_STAT) & ~bus_wdata[ST_DONE];
   assign stat_clr_nack = wr_en & (idx == IDX_STAT) & ~bus_wdata[ST_NACK];

   // configuration words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         addr_q  <= '0;
         count_q <= '0;
         hs_q    <= '0;
         div0_q  <= '0;
         div1_q  <= '0;
         hold_q  <= '0;
      end else if (wr_en) begin
         case (idx)
            IDX_CTL:   ctl_q   <= bus_wdata;
            IDX_ADDR:  addr_q  <= bus_wdata;
            IDX_COUNT: count_q <= bus_wdata;
            IDX_HS:    hs_q    <= bus_wdata;
            IDX_DIV0:  div0_q  <= bus_wdata;
            IDX_DIV1:  div1_q  <= bus_wdata;
            IDX_HOLD:  hold_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   // sticky event flags, set has priority over write-zero clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         nack_q <= 1'b0;
      end else begin
         if (eng_done)           done_q <= 1'b1;
         else if (stat_clr_done) done_q <= 1'b0;
         if (eng_nack)           nack_q <= 1'b1;
         else if (stat_clr_nack) nack_q <= 1'b0;
      end
   end

   i2cm_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_req),
      .push  (tx_push),
      .wdata (bus_wdata[BYTE_W-1:0]),
      .pop   (eng_tx_pop),
      .rdata (eng_tx_data),
      .count (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty)
   );

   i2cm_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_req),
      .push  (eng_rx_push),
      .wdata (eng_rx_data),
      .pop   (rx_pop),
      .rdata (rx_head),
      .count (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign eng_tx_avail = ~tx_empty;

   always_comb begin
      stat_w             = '0;
      stat_w[ST_SDA]     = sda_in;
      stat_w[ST_SCL]     = scl_in;
      stat_w[ST_TXFULL]  = tx_full;
      stat_w[ST_RXEMPTY] = rx_empty;
      stat_w[ST_DONE]    = done_q;
      stat_w[ST_NACK]    = nack_q;
      stat_w[ST_BUSY]    = eng_busy;
   end

   // read mux, combinational in the access cycle
   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         case (idx)
            IDX_CTL:   bus_rdata = ctl_q;
            IDX_ADDR:  bus_rdata = addr_q;
            IDX_COUNT: bus_rdata = count_q;
            IDX_RXD:   bus_rdata = {{(DATA_W-BYTE_W){1'b0}}, rx_head};
            IDX_STAT:  bus_rdata = stat_w;
            IDX_HS:    bus_rdata = hs_q;
            IDX_VER:   bus_rdata = VERSION;
            IDX_DIV0:  bus_rdata = div0_q;
            IDX_DIV1:  bus_rdata = div1_q;
            IDX_HOLD:  bus_rdata = hold_q;
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign irq_en = ctl_q[CT_IRQ_EN];

   i2cm_irq_gen #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_irq (
      .rx_cnt   (rx_cnt),
      .tx_cnt   (tx_cnt),
      .af_lvl   (ctl_q[CT_AF_LSB +: LVL_W]),
      .ae_lvl   (ctl_q[CT_AE_LSB +: LVL_W]),
      .full_ie  (ctl_q[CT_FULL_IE]),
      .empty_ie (ctl_q[CT_EMPTY_IE]),
      .irq_en   (irq_en),
      .done     (done_q),
      .irq_raw  (irq_raw)
   );

   // output variant: direct or retimed interrupt line
   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   assign cfg_ctl   = ctl_q;
   assign cfg_addr  = addr_q;
   assign cfg_count = count_q;
   assign cfg_hs    = hs_q;
   assign cfg_div0  = div0_q;
   assign cfg_div1  = div1_q;
   assign cfg_hold  = hold_q;
endmodule

// File: rtl/i2cm_regfile_chk.sv
module i2cm_regfile_chk #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] tx_cnt,
   input logic [CNT_W-1:0] rx_cnt,
   input logic             flush_req,
   input logic             done_q,
   input logic             stat_clr_done,
   input logic             eng_done,
   input logic             irq_en,
   input logic             irq
);
   // R3: transmit occupancy never exceeds the depth
   a_r3_tx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CNT_W'(DEPTH));

   // R4: receive occupancy never exceeds the depth
   a_r4_rx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CNT_W'(DEPTH));

   // R3: without a flush the transmit occupancy moves by at most one
   a_r3_tx_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_req |=> (tx_cnt == $past(tx_cnt)) || (tx_cnt == $past(tx_cnt) + 1'b1)
                     || (tx_cnt + 1'b1 == $past(tx_cnt)));

   // R5: a flush leaves both FIFOs empty
   a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> (tx_cnt == '0) && (rx_cnt == '0));

   // R7: done stays set until a write-zero clear
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !stat_clr_done |=> done_q);

   // R7: a set pulse wins over a clear in the same cycle
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> done_q);

   // R10: a disabled interrupt output stays low
   a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !$past(irq_en)) |-> !irq);
endmodule

bind i2cm_regfile i2cm_regfile_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_cnt        (tx_cnt),
   .rx_cnt        (rx_cnt),
   .flush_req     (flush_req),
   .done_q        (done_q),
   .stat_clr_done (stat_clr_done),
   .eng_done      (eng_done),
   .irq_en        (irq_en),
   .irq           (irq)
);

// File: tb/i2cm_regfile_test.sv
module i2cm_regfile_test;
   localparam int PERIOD = 10;
   localparam int DEPTH  = 16;
   localparam logic [31:0] VER = 32'h0000_0101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [7:0]  eng_tx_data;
   logic        eng_tx_avail;
   logic        eng_rx_push = 1'b0;
   logic [7:0]  eng_rx_data = '0;
   logic        eng_done = 1'b0, eng_nack = 1'b0, eng_busy = 1'b0;
   logic        scl_in = 1'b1, sda_in = 1'b1;
   logic [31:0] cfg_ctl, cfg_addr, cfg_count, cfg_hs, cfg_div0, cfg_div1, cfg_hold;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   // reference model state
   logic [7:0]  txq[$];
   logic [7:0]  rxq[$];
   logic [31:0] m_ctl, m_addr, m_cnt, m_hs, m_div0, m_div1, m_hold;
   bit          m_done, m_nack;

   always #(PERIOD/2) clk = ~clk;

   i2cm_regfile #(.VERSION(VER)) uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_done(eng_done),
      .eng_nack(eng_nack), .eng_busy(eng_busy), .scl_in(scl_in), .sda_in(sda_in),
      .cfg_ctl(cfg_ctl), .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_hs(cfg_hs),
      .cfg_div0(cfg_div0), .cfg_div1(cfg_div1), .cfg_hold(cfg_hold), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_status();
      logic [31:0] s = '0;
      s[21] = sda_in;
      s[20] = scl_in;
      s[4]  = (txq.size() == DEPTH);
      s[3]  = (rxq.size() == 0);
      s[2]  = m_done;
      s[1]  = m_nack;
      s[0]  = eng_busy;
      return s;
   endfunction

   function automatic logic [31:0] m_rdata();
      if (!bus_valid || bus_write || bus_addr[1:0] != 2'b00) return '0;
      case (int'(bus_addr[5:2]))
         0:  return m_ctl;
         1:  return m_addr;
         2:  return m_cnt;
         3:  return (rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
         5:  return m_status();
         6:  return m_hs;
         7:  return VER;
         8:  return m_div0;
         9:  return m_div1;
         10: return m_hold;
         default: return '0;
      endcase
   endfunction

   function automatic logic m_irq();
      logic af, ae;
      af = m_ctl[10] && (rxq.size() >= int'(m_ctl[19:16]));
      ae = m_ctl[9]  && (txq.size() <= int'(m_ctl[15:12]));
      return m_ctl[1] && (m_done || af || ae);
   endfunction

   task automatic compare_all();
      string rtag;
      case (int'(bus_addr[5:2]))
         3:       rtag = "R4 rx read";
         5:       rtag = "R6 status";
         default: rtag = "R2 readback";
      endcase
      check("R10 irq", {31'h0, irq}, {31'h0, m_irq()});
      check("R3 tx head", {24'h0, eng_tx_data}, (txq.size() > 0) ? {24'h0, txq[0]} : 32'h0);
      check("R3 tx avail", {31'h0, eng_tx_avail}, {31'h0, txq.size() > 0});
      check(rtag, bus_rdata, m_rdata());
   endtask

   task automatic model_update();
      bit w, r, fl;
      int ix;
      bit tpop, tpush, rpop, rpush;
      w  = bus_valid && bus_write && bus_addr[1:0] == 2'b00;
      r  = bus_valid && !bus_write && bus_addr[1:0] == 2'b00;
      ix = int'(bus_addr[5:2]);
      fl = w && ix == 11 && bus_wdata[0];
      tpop  = eng_tx_pop && txq.size() > 0;
      tpush = w && ix == 4 && txq.size() < DEPTH;
      rpop  = r && ix == 3 && rxq.size() > 0;
      rpush = eng_rx_push && rxq.size() < DEPTH;
      if (fl) begin
         txq.delete();
         rxq.delete();
      end else begin
         if (tpop)  void'(txq.pop_front());
         if (tpush) txq.push_back(bus_wdata[7:0]);
         if (rpop)  void'(rxq.pop_front());
         if (rpush) rxq.push_back(eng_rx_data);
      end
      if (w) begin
         case (ix)
            0:  m_ctl  = bus_wdata;
            1:  m_addr = bus_wdata;
            2:  m_cnt  = bus_wdata;
            6:  m_hs   = bus_wdata;
            8:  m_div0 = bus_wdata;
            9:  m_div1 = bus_wdata;
            10: m_hold = bus_wdata;
            default: ;
         endcase
      end
      if (eng_done) m_done = 1'b1;
      else if (w && ix == 5 && !bus_wdata[2]) m_done = 1'b0;
      if (eng_nack) m_nack = 1'b1;
      else if (w && ix == 5 && !bus_wdata[1]) m_nack = 1'b0;
   endtask

   // one clock: compare at the negedge, update the model at the posedge
   task automatic cycle();
      #1;
      compare_all();
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      cycle();
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic bread(input logic [5:0] a, input logic [31:0] exp, input string tag);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      cycle();
      bus_valid = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_data = b;
      cycle();
      eng_rx_push = 1'b0;
   endtask

   task automatic tx_out();
      eng_tx_pop = 1'b1;
      cycle();
      eng_tx_pop = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      m_ctl = '0; m_addr = '0; m_cnt = '0; m_hs = '0;
      m_div0 = '0; m_div1 = '0; m_hold = '0; m_done = 1'b0; m_nack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #1;
      check("R1 irq low", {31'h0, irq}, 32'h0);
      check("R1 tx empty", {31'h0, eng_tx_avail}, 32'h0);
      bread(6'h00, 32'h0, "R1 ctl");
      bread(6'h24, 32'h0, "R1 div1");
      bread(6'h14, 32'h0030_0008, "R1 status");

      // R2 storage, version, unmapped and misaligned
      bwrite(6'h04, 32'h0000_002A);
      bwrite(6'h08, 32'h0000_0010);
      bwrite(6'h18, 32'hCAFE_0005);
      bwrite(6'h20, 32'h1234_5678);
      bwrite(6'h24, 32'h8000_0009);
      bwrite(6'h28, 32'h0000_0068);
      bread(6'h04, 32'h0000_002A, "R2 addr");
      bread(6'h08, 32'h0000_0010, "R2 count");
      bread(6'h18, 32'hCAFE_0005, "R2 hs");
      bread(6'h20, 32'h1234_5678, "R2 div0");
      bread(6'h24, 32'h8000_0009, "R2 div1");
      bread(6'h28, 32'h0000_0068, "R2 hold");
      bread(6'h1C, VER, "R2 version");
      bread(6'h34, 32'h0, "R2 unmapped");
      bread(6'h10, 32'h0, "R2 tx port reads zero");
      bwrite(6'h05, 32'hFFFF_FFFF);
      bread(6'h04, 32'h0000_002A, "R2 misaligned write ignored");
      bread(6'h06, 32'h0, "R2 misaligned read");

      // R3 transmit order and overflow
      bwrite(6'h10, 32'hFFFF_FFA1);
      bwrite(6'h10, 32'h0000_00B2);
      bwrite(6'h10, 32'h0000_00C3);
      check("R3 head A1", {24'h0, eng_tx_data}, 32'hA1);
      tx_out();
      check("R3 head B2", {24'h0, eng_tx_data}, 32'hB2);
      tx_out();
      tx_out();
      check("R3 drained", {31'h0, eng_tx_avail}, 32'h0);
      for (int i = 0; i < DEPTH + 2; i++) bwrite(6'h10, 32'h40 + i);
      bread(6'h14, 32'h0030_0018, "R3 full status");
      for (int i = 0; i < DEPTH; i++) begin
         check("R3 fill order", {24'h0, eng_tx_data}, 32'h40 + i);
         tx_out();
      end
      check("R3 overflow dropped", {31'h0, eng_tx_avail}, 32'h0);

      // R4 receive order, empty read, overflow
      for (int i = 0; i < 5; i++) rx_in(8'(8'h70 + i));
      for (int i = 0; i < 5; i++) bread(6'h0C, 32'h70 + i, "R4 rx order");
      bread(6'h0C, 32'h0, "R4 empty read");
      bread(6'h14, 32'h0030_0008, "R4 empty after empty read");
      for (int i = 0; i < DEPTH + 1; i++) rx_in(8'(8'h80 + i));
      bread(6'h14, 32'h0030_0000, "R4 rx non-empty status");
      for (int i = 0; i < DEPTH; i++) bread(6'h0C, 32'h80 + i, "R4 fill order");
      bread(6'h0C, 32'h0, "R4 overflow dropped");

      // R5 flush
      bwrite(6'h10, 32'h11);
      bwrite(6'h10, 32'h22);
      rx_in(8'h33);
      bwrite(6'h2C, 32'h0);
      check("R5 bit0 clear keeps tx", {31'h0, eng_tx_avail}, 32'h1);
      bread(6'h14, 32'h0030_0000, "R5 bit0 clear keeps rx");
      bwrite(6'h2C, 32'h1);
      check("R5 flush tx", {31'h0, eng_tx_avail}, 32'h0);
      bread(6'h14, 32'h0030_0008, "R5 flush rx");

      // R6 status layout
      scl_in = 1'b0; eng_busy = 1'b1;
      bread(6'h14, 32'h0020_0009, "R6 lines and busy");
      scl_in = 1'b1; sda_in = 1'b0;
      bread(6'h14, 32'h0010_0009, "R6 sda low");
      sda_in = 1'b1; eng_busy = 1'b0;

      // R7 write-zero clear
      eng_done = 1'b1; cycle(); eng_done = 1'b0;
      eng_nack = 1'b1; cycle(); eng_nack = 1'b0;
      bread(6'h14, 32'h0030_000E, "R7 flags set");
      bwrite(6'h14, 32'hFFFF_FFFF);
      bread(6'h14, 32'h0030_000E, "R7 ones keep flags");
      bwrite(6'h14, 32'h0000_0002);
      bread(6'h14, 32'h0030_000A, "R7 clear done only");
      bwrite(6'h14, 32'h0);
      bread(6'h14, 32'h0030_0008, "R7 clear nack");
      eng_done = 1'b1;
      bwrite(6'h14, 32'h0);
      eng_done = 1'b0;
      bread(6'h14, 32'h0030_000C, "R7 set wins");

      // R10 combine and mask (done is set)
      check("R10 masked", {31'h0, irq}, 32'h0);
      bwrite(6'h00, 32'h0000_0002);
      check("R10 done raises irq", {31'h0, irq}, 32'h1);
      bwrite(6'h14, 32'h0);
      check("R10 done cleared", {31'h0, irq}, 32'h0);

      // R8 almost-full level 3
      bwrite(6'h00, 32'h0003_0402);
      rx_in(8'h01);
      rx_in(8'h02);
      check("R8 below level", {31'h0, irq}, 32'h0);
      rx_in(8'h03);
      check("R8 at level", {31'h0, irq}, 32'h1);
      bread(6'h0C, 32'h01, "R8 read drops below");
      check("R8 after read", {31'h0, irq}, 32'h0);
      bwrite(6'h2C, 32'h1);
      bwrite(6'h00, 32'h0000_0402);
      check("R8 level zero on empty", {31'h0, irq}, 32'h1);
      bwrite(6'h00, 32'h0003_0002);
      check("R8 enable clear", {31'h0, irq}, 32'h0);

      // R9 almost-empty level 2
      bwrite(6'h00, 32'h0000_2202);
      check("R9 empty fifo", {31'h0, irq}, 32'h1);
      bwrite(6'h10, 32'h5);
      bwrite(6'h10, 32'h6);
      check("R9 at level", {31'h0, irq}, 32'h1);
      bwrite(6'h10, 32'h7);
      check("R9 above level", {31'h0, irq}, 32'h0);
      tx_out();
      check("R9 back at level", {31'h0, irq}, 32'h1);
      bwrite(6'h00, 32'h0000_2200);
      check("R10 output disabled", {31'h0, irq}, 32'h0);

      cycle();
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule